// File: doc/BRIEF.md
# Iterative Multiplier with Deferred Input Acknowledge

This block places a multi-cycle multiplier between two ready/valid links. An upstream producer offers a pair of unsigned operands. The block copies them into a holding register as soon as it sees valid, provided it is idle and has no unread result. The block does not acknowledge the offer at that point. The captured item raises an internal valid flag. A rising-edge detector turns that flag into a one-cycle start pulse for a datapath, which builds the product by adding the first operand to an accumulator once per unit of the second operand.

When the datapath reports that it has finished, the control logic raises the upstream ready for a single cycle. The product is placed on the downstream port in the same cycle. Input ready is therefore a "send the next item" signal rather than a buffer-space flag. The upstream source must hold valid and the operands steady until that pulse arrives. The block takes no further item until the downstream consumer has accepted the current product.

Both outputs that the handshakes depend on, input ready and output valid, come straight from registers. No combinational path links them to the valid or ready inputs.

Top module: `iter_mul_wrap`

## Requirements
- R1: While `rst_n` is low, `in_ready` and `out_valid` are 0, and this holds at once when reset is asserted in the middle of a calculation.
- R2: `out_data` equals the unsigned product `in_a * in_b` (2*W bits, operand a in `in_a`, operand b in `in_b`) of the item being answered, including operands of 0 and all-ones.
- R3: When an item is offered while the block is idle and holds no unread result, `out_valid` first reads 1 exactly 3 + `in_b` cycles after the cycle in which the item was first offered.
- R4: `in_ready` is 1 for exactly one cycle per item: the cycle in which `out_valid` rises. It is 0 in every other cycle.
- R5: While `out_valid` is 1 and `out_ready` is 0, `out_valid` stays 1 and `out_data` stays unchanged. `out_valid` reads 0 in the cycle after a cycle in which both are 1.
- R6: While a result is unread, an offered item is neither acknowledged nor captured, and the pending result is not overwritten. The item counts as first offered in the cycle after the downstream handshake.
- R7: The datapath is started by a single-cycle pulse on the rise of the internal item-valid flag, and never while it is already running.
- R8: The captured operands change only when a new item is loaded into an empty holding register. The holding register empties only in a cycle where `in_valid` and `in_ready` are both 1.
- R9: With `in_valid` held at 0, the block stays idle: `out_valid` and `in_ready` remain 0 whatever `out_ready` does.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| in_valid | input | 1 | Upstream offers an operand pair |
| in_a | input | W | Operand a (multiplicand) |
| in_b | input | W | Operand b (iteration count) |
| in_ready | output | 1 | One-cycle acknowledge once the item has been processed |
| out_valid | output | 1 | Product available |
| out_data | output | 2*W | Product a*b |
| out_ready | input | 1 | Downstream accepts the product |

## Verification
Each result has a fixed due cycle that depends on the data. The product and the single `in_ready` pulse appear together 3 + b cycles after the first cycle in which an item is offered to an idle block. The offer counts from the cycle after the downstream handshake when a result is still pending. `out_valid` drops in the cycle after the output handshake. The bench drives inputs on falling edges and counts the rising edges that pass between a stimulus and the sample. Each check compares the counted value to the cycle count the requirement gives for that operand, so an early or late answer fails the timing check as well as the data check. Results are held back for a different number of cycles for each vector, to test that they stay stable.

// File: rtl/mulw_pkg.sv
package mulw_pkg;
  // Cycles of overhead beyond the b additions: capture, start, final step.
  localparam int unsigned FIXED_LAT = 3;

  typedef enum logic {
    DP_IDLE = 1'b0,
    DP_RUN  = 1'b1
  } dp_phase_t;
endpackage

// File: rtl/hsw_capture.sv
module hsw_capture #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic [W-1:0] in_a,
  input  logic [W-1:0] in_b,
  input  logic         take_en,
  input  logic         calc_done,
  output logic         in_ready,
  output logic         item_vld,
  output logic [W-1:0] item_a,
  output logic [W-1:0] item_b
);
  // Single handshake-complete term gating the release of the holding register.
  logic hs_in;
  logic load;
  logic vld_d;
  logic rdy_d;

  assign hs_in = in_valid & in_ready;
  assign load  = ~item_vld & in_valid & take_en;

  always_comb begin
    vld_d = item_vld;
    if (load) begin
      vld_d = 1'b1;
    end else if (hs_in) begin
      vld_d = 1'b0;
    end
    rdy_d = calc_done;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      item_vld <= 1'b0;
      in_ready <= 1'b0;
      item_a   <= '0;
      item_b   <= '0;
    end else begin
      item_vld <= vld_d;
      in_ready <= rdy_d;
      if (load) begin
        item_a <= in_a;
        item_b <= in_b;
      end
    end
  end

  assert_ready_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |=> !in_ready);
  assert_ready_has_item_R4: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> item_vld);
  assert_item_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (item_vld && !hs_in) |=> (item_vld && $stable(item_a) && $stable(item_b)));
  assert_release_on_hs_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(item_vld) |-> $past(hs_in));
endmodule

// File: rtl/hsw_rise_pulse.sv
module hsw_rise_pulse (
  input  logic clk,
  input  logic rst_n,
  input  logic level,
  output logic pulse
);
  logic level_q;

  assign pulse = level & ~level_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level_q <= 1'b0;
    end else begin
      level_q <= level;
    end
  end

  assert_pulse_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pulse |=> !pulse);
endmodule

// File: rtl/hsw_iter_mul.sv
module hsw_iter_mul
  import mulw_pkg::*;
#(
  parameter int W = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [W-1:0]   opa,
  input  logic [W-1:0]   opb,
  output logic           done,
  output logic [2*W-1:0] product
);
  localparam int PW = 2 * W;

  dp_phase_t       phase_q, phase_d;
  logic [W-1:0]    cnt_q, cnt_d;
  logic [PW-1:0]   acc_q, acc_d;
  logic            cnt_zero;

  assign cnt_zero = (cnt_q == '0);

  always_comb begin
    phase_d = phase_q;
    cnt_d   = cnt_q;
    acc_d   = acc_q;
    case (phase_q)
      DP_IDLE: begin
        if (start) begin
          phase_d = DP_RUN;
          cnt_d   = opb;
          acc_d   = '0;
        end
      end
      DP_RUN: begin
        if (cnt_zero) begin
          phase_d = DP_IDLE;
        end else begin
          cnt_d = cnt_q - {{(W-1){1'b0}}, 1'b1};
          acc_d = acc_q + {{W{1'b0}}, opa};
        end
      end
      default: phase_d = DP_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= DP_IDLE;
      cnt_q   <= '0;
      acc_q   <= '0;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
      acc_q   <= acc_d;
    end
  end

  assign done    = (phase_q == DP_RUN) && cnt_zero;
  assign product = acc_q;

  assert_no_restart_R7: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> (phase_q == DP_IDLE));
  assert_done_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

// File: rtl/hsw_result_hold.sv
module hsw_result_hold #(
  parameter int W = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load,
  input  logic [2*W-1:0] din,
  input  logic           out_ready,
  output logic           out_valid,
  output logic [2*W-1:0] out_data
);
  logic hs_out;
  logic vld_d;

  assign hs_out = out_valid & out_ready;

  always_comb begin
    vld_d = out_valid;
    if (load) begin
      vld_d = 1'b1;
    end else if (hs_out) begin
      vld_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= vld_d;
      if (load) begin
        out_data <= din;
      end
    end
  end

  assert_out_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
  assert_out_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    hs_out |=> !out_valid);
  assert_no_overwrite_R6: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> !out_valid);
endmodule

// File: rtl/iter_mul_wrap.sv
module iter_mul_wrap #(
  parameter int W = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_valid,
  input  logic [W-1:0]   in_a,
  input  logic [W-1:0]   in_b,
  output logic           in_ready,
  output logic           out_valid,
  output logic [2*W-1:0] out_data,
  input  logic           out_ready
);
  logic           item_vld;
  logic [W-1:0]   item_a;
  logic [W-1:0]   item_b;
  logic           start;
  logic           done;
  logic [2*W-1:0] product;
  logic           take_en;

  // New items wait until the previous product has been read.
  assign take_en = ~out_valid;

  hsw_capture #(.W(W)) u_cap (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_a      (in_a),
    .in_b      (in_b),
    .take_en   (take_en),
    .calc_done (done),
    .in_ready  (in_ready),
    .item_vld  (item_vld),
    .item_a    (item_a),
    .item_b    (item_b)
  );

  hsw_rise_pulse u_edge (
    .clk   (clk),
    .rst_n (rst_n),
    .level (item_vld),
    .pulse (start)
  );

  hsw_iter_mul #(.W(W)) u_mul (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .opa     (item_a),
    .opb     (item_b),
    .done    (done),
    .product (product)
  );

  hsw_result_hold #(.W(W)) u_res (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (done),
    .din       (product),
    .out_ready (out_ready),
    .out_valid (out_valid),
    .out_data  (out_data)
  );

  assert_ready_with_result_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_ready) |-> $rose(out_valid));
  assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !item_vld |-> !in_ready);
endmodule

// File: tb/tb_iter_mul_wrap.sv
`timescale 1ns/1ps
module tb_iter_mul_wrap;
  localparam int W = 8;
  localparam int NV = 8;
  // Each entry: {a, b}
  localparam logic [15:0] VEC [NV] = '{
    16'h0304, 16'h0007, 16'h0900, 16'hFF01,
    16'h01FF, 16'h110D, 16'hFFFF, 16'h64C8
  };

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           in_valid = 1'b0;
  logic [W-1:0]   in_a = '0;
  logic [W-1:0]   in_b = '0;
  logic           in_ready;
  logic           out_valid;
  logic [2*W-1:0] out_data;
  logic           out_ready = 1'b0;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  iter_mul_wrap #(.W(W)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_a(in_a), .in_b(in_b),
    .in_ready(in_ready), .out_valid(out_valid), .out_data(out_data),
    .out_ready(out_ready)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Count rising edges from the current falling edge until out_valid reads 1.
  task automatic wait_result(input int b, input int a, output int n);
    n = 0;
    while (!out_valid && n < 400) begin
      @(negedge clk);
      n++;
    end
    chk(n == b + 3, "R3 R7 latency", n, b + 3);
    chk(out_data == a * b, "R2 product", out_data, a * b);
    chk(in_ready == 1'b1, "R4 ready with result", in_ready, 1);
  endtask

  task automatic take_result(input int hold, input int a, input int b);
    for (int k = 0; k < hold; k++) begin
      @(negedge clk);
      chk(out_valid && out_data == a * b, "R5 hold", out_data, a * b);
    end
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
    chk(out_valid == 1'b0, "R5 drop after take", out_valid, 0);
  endtask

  task automatic run_item(input int a, input int b, input int hold);
    int n;
    @(negedge clk);
    in_valid = 1'b1;
    in_a = W'(a);
    in_b = W'(b);
    wait_result(b, a, n);
    @(negedge clk);
    in_valid = 1'b0;
    chk(in_ready == 1'b0, "R4 single pulse", in_ready, 0);
    take_result(hold, a, b);
  endtask

  initial begin
    int n;
    // R1: reset state
    #1;
    chk(in_ready == 1'b0 && out_valid == 1'b0, "R1 reset", {in_ready, out_valid}, 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // Table walk: R2 R3 R4 R5 R7
    for (int i = 0; i < NV; i++) begin
      run_item(int'(VEC[i][15:8]), int'(VEC[i][7:0]), i % 4 + 1);
    end

    // R9: no valid, toggling out_ready
    for (int k = 0; k < 10; k++) begin
      @(negedge clk);
      out_ready = k[0];
      chk(out_valid == 1'b0 && in_ready == 1'b0, "R9 idle", {in_ready, out_valid}, 0);
    end
    out_ready = 1'b0;

    // R6: second item offered while the first result is unread
    @(negedge clk);
    in_valid = 1'b1; in_a = 8'd7; in_b = 8'd5;
    wait_result(5, 7, n);
    @(negedge clk);
    in_a = 8'd12; in_b = 8'd9;   // next item offered at once, R8 hold of the old one
    for (int k = 0; k < 15; k++) begin
      chk(in_ready == 1'b0, "R6 no ack while pending", in_ready, 0);
      chk(out_valid && out_data == 35, "R6 pending kept", out_data, 35);
      @(negedge clk);
    end
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
    chk(out_valid == 1'b0, "R5 drop after take", out_valid, 0);
    wait_result(9, 12, n);
    @(negedge clk);
    in_valid = 1'b0;
    take_result(2, 12, 9);

    // R1: reset during a calculation
    @(negedge clk);
    in_valid = 1'b1; in_a = 8'd5; in_b = 8'd200;
    repeat (20) @(negedge clk);
    rst_n = 1'b0;
    in_valid = 1'b0;
    #1;
    chk(in_ready == 1'b0 && out_valid == 1'b0, "R1 mid reset", {in_ready, out_valid}, 0);
    @(negedge clk);
    rst_n = 1'b1;
    run_item(6, 7, 1);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule